// File: doc/BRIEF.md
# SPI Target Port with Double-Buffered Transmit

This block is the target side of a serial peripheral link. An external controller drives the serial clock and the active-low select line. The block never starts a transfer. Each byte moves in both directions at once: bits from MOSI enter a shift register while the bits of the transmit byte leave on MISO, most significant bit first. The only clock mode is mode 0, in which the clock idles low, MOSI is sampled on the rising edge and MISO changes after the falling edge. All bus inputs pass through two-flop synchronizers into the system clock domain. Edges are found there, so the system clock has to run at least four times faster than SCK.

The host side looks like one data register. A host write lands in a one-entry holding buffer. That buffer moves into the shift register at once if the shift register has no pending transmit byte and no byte is partly shifted. Otherwise the buffer waits until the eighth rising SCK edge of the current or next transfer. The host read data always shows the receive buffer. When a byte completes, the receive buffer takes it and a done flag is set. The done flag stays set until the host pulses a clear strobe. A byte that completes while the done flag is still set also raises an overrun flag.

Top module: `spi_target_port`

## Requirements
- R1: After reset, misoOe is 0, doneFlag and overrunFlag are 0, and hostRdData is 0x00.
- R2: The bit order is MSB first in both directions. MOSI is sampled at each rising SCK edge. The first MISO bit appears once select goes low, and each later bit appears after a falling SCK edge.
- R3: After the eighth rising SCK edge of a byte, hostRdData shows the received byte and doneFlag is 1.
- R4: hostRdData changes only when a byte completes.
- R5: A host write while the shift register holds no transmit byte and no byte is partly shifted loads the shift register at once, and that byte goes out in the next transfer.
- R6: A host write while the shift register holds a byte, or while a byte is partly shifted, stays in the holding buffer. It enters the shift register at the eighth rising edge of the transfer in progress and goes out in the byte after that. Back-to-back bytes under one select therefore send the loaded byte and then the held byte.
- R7: A byte for which no data was loaded sends 0xFF on MISO.
- R8: doneFlag stays 1 until a one-cycle pulse on doneClr. A byte completing in the same cycle as the clear wins over the clear.
- R9: If a byte completes while doneFlag is already 1, overrunFlag becomes 1 and hostRdData takes the newer byte. A doneClr pulse clears overrunFlag as well.
- R10: While select is high, misoOe is 0 and the bit counter is held at zero. Raising select in the middle of a byte discards that byte: doneFlag is not set, hostRdData is unchanged, and a transmit byte in the shift register is dropped, so the next byte sends 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x SCK |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Serial clock from the controller (asynchronous) |
| mosiIn | input | 1 | Serial data from the controller (asynchronous) |
| selN | input | 1 | Active-low target select (asynchronous) |
| misoOut | output | 1 | Serial data to the controller |
| misoOe | output | 1 | Output enable for misoOut, high while selected |
| hostWrEn | input | 1 | One-cycle host write strobe for the data register |
| hostWrData | input | 8 | Host write data for the holding buffer |
| hostRdData | output | 8 | Receive buffer contents |
| doneClr | input | 1 | One-cycle pulse that clears the done and overrun flags |
| doneFlag | output | 1 | Byte transfer complete |
| overrunFlag | output | 1 | A byte completed while doneFlag was still set |

## Verification
The assertions assume that SCK, MOSI and select change slowly enough for every level to last at least two system clocks after synchronization. They also assume that MOSI is stable around each rising SCK edge and that doneClr and hostWrEn are single-cycle pulses. The bench model of the controller holds every SCK phase for eight system clocks. It changes MOSI only while SCK is low, and it lets select settle for eight clocks before the first edge. Host strobes are driven for exactly one cycle on the falling system clock edge.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  // Strobes from the control unit to the datapath, valid for one clock.
  typedef struct packed {
    logic shiftEn;    // rising SCK edge: shift MOSI in
    logic presentEn;  // falling SCK edge: present next MISO bit
    logic selStart;   // select just went active: present first bit
    logic loadNow;    // move holding buffer into shift register now
    logic byteDone;   // last rising edge of a byte
    logic loadAtEnd;  // with byteDone: holding buffer refills shift reg
    logic abort;      // select released mid-byte
    logic mosiBit;    // synchronized MOSI level
  } tgtStrobes_t;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= RST_VAL;
    end else begin
      stageQ[0] <= din;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/spi_tgt_ctrl.sv
module spi_tgt_ctrl
  import spi_tgt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sckIn,
  input  logic        mosiIn,
  input  logic        selN,
  input  logic        hostWrEn,
  input  logic        doneClr,
  output tgtStrobes_t strb,
  output logic        selActive,
  output logic        holdValid,
  output logic        shiftFull,
  output logic        doneFlag,
  output logic        overrunFlag
);

  localparam int              CNT_W    = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [2:0]       syncOut;
  logic             sckS, mosiS, selNS;
  logic             sckPrev, selActPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             rise, fall, lastBit, abortNow, loadNow;

  spi_tgt_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({selN, mosiIn, sckIn}),
    .dout(syncOut)
  );

  assign sckS      = syncOut[0];
  assign mosiS     = syncOut[1];
  assign selNS     = syncOut[2];
  assign selActive = ~selNS;

  always_comb begin
    rise     = selActive & sckS & ~sckPrev;
    fall     = selActive & ~sckS & sckPrev;
    lastBit  = rise && (bitCnt == LAST_BIT);
    abortNow = ~selActive & selActPrev & (bitCnt != '0);
    loadNow  = holdValid & ~shiftFull & (bitCnt == '0) & ~rise & ~abortNow;

    strb.shiftEn   = rise;
    strb.presentEn = fall;
    strb.selStart  = selActive & ~selActPrev;
    strb.loadNow   = loadNow;
    strb.byteDone  = lastBit;
    strb.loadAtEnd = lastBit & holdValid;
    strb.abort     = abortNow;
    strb.mosiBit   = mosiS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev     <= 1'b0;
      selActPrev  <= 1'b0;
      bitCnt      <= '0;
      holdValid   <= 1'b0;
      shiftFull   <= 1'b0;
      doneFlag    <= 1'b0;
      overrunFlag <= 1'b0;
    end else begin
      sckPrev    <= sckS;
      selActPrev <= selActive;

      if (!selActive)   bitCnt <= '0;
      else if (lastBit) bitCnt <= '0;
      else if (rise)    bitCnt <= bitCnt + 1'b1;

      if (hostWrEn)                 holdValid <= 1'b1;
      else if (loadNow || lastBit)  holdValid <= 1'b0;

      if (abortNow)     shiftFull <= 1'b0;
      else if (lastBit) shiftFull <= holdValid;
      else if (loadNow) shiftFull <= 1'b1;

      if (lastBit) begin
        doneFlag <= 1'b1;
        if (doneFlag) overrunFlag <= 1'b1;
      end else if (doneClr) begin
        doneFlag    <= 1'b0;
        overrunFlag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spi_tgt_dp.sv
module spi_tgt_dp
  import spi_tgt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tgtStrobes_t       strb,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  output logic              misoBit,
  output logic [DATA_W-1:0] rxBuf
);

  localparam logic [DATA_W-1:0] IDLE_FILL = '1;

  logic [DATA_W-1:0] holdBuf;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shiftNext;

  assign shiftNext = {shiftReg[DATA_W-2:0], strb.mosiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdBuf  <= '0;
      shiftReg <= IDLE_FILL;
      rxBuf    <= '0;
      misoBit  <= 1'b1;
    end else begin
      if (hostWrEn) holdBuf <= hostWrData;

      if (strb.abort)         shiftReg <= IDLE_FILL;
      else if (strb.byteDone) shiftReg <= strb.loadAtEnd ? holdBuf : IDLE_FILL;
      else if (strb.shiftEn)  shiftReg <= shiftNext;
      else if (strb.loadNow)  shiftReg <= holdBuf;

      if (strb.byteDone) rxBuf <= shiftNext;

      if (strb.loadNow)                         misoBit <= holdBuf[DATA_W-1];
      else if (strb.presentEn || strb.selStart) misoBit <= shiftReg[DATA_W-1];
    end
  end

endmodule

// File: rtl/spi_target_port.sv
module spi_target_port
  import spi_tgt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              selN,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              doneClr,
  output logic              doneFlag,
  output logic              overrunFlag
);

  tgtStrobes_t strb;
  logic        selActive, holdValid, shiftFull, misoBit;

  spi_tgt_ctrl #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sckIn      (sckIn),
    .mosiIn     (mosiIn),
    .selN       (selN),
    .hostWrEn   (hostWrEn),
    .doneClr    (doneClr),
    .strb       (strb),
    .selActive  (selActive),
    .holdValid  (holdValid),
    .shiftFull  (shiftFull),
    .doneFlag   (doneFlag),
    .overrunFlag(overrunFlag)
  );

  spi_tgt_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .hostWrEn  (hostWrEn),
    .hostWrData(hostWrData),
    .misoBit   (misoBit),
    .rxBuf     (hostRdData)
  );

  assign misoOut = misoBit;
  assign misoOe  = selActive;

endmodule

// File: rtl/spi_target_port_chk.sv
module spi_target_port_chk
  import spi_tgt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input tgtStrobes_t       strb,
  input logic              holdValid,
  input logic              hostWrEn,
  input logic              doneClr,
  input logic              doneFlag,
  input logic              overrunFlag,
  input logic [DATA_W-1:0] hostRdData
);

  p_done_on_byte_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteDone |=> doneFlag);

  p_rx_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.byteDone |=> $stable(hostRdData));

  p_hold_drains_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.byteDone && holdValid && !hostWrEn) |=> !holdValid);

  p_clear_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneClr && !strb.byteDone) |=> (!doneFlag && !overrunFlag));

  p_overrun_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.byteDone && doneFlag) |=> overrunFlag);

  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> $stable(hostRdData));

endmodule

bind spi_target_port spi_target_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .strb       (strb),
  .holdValid  (holdValid),
  .hostWrEn   (hostWrEn),
  .doneClr    (doneClr),
  .doneFlag   (doneFlag),
  .overrunFlag(overrunFlag),
  .hostRdData (hostRdData)
);

// File: tb/spi_target_port_bench.sv
`timescale 1ns/1ps
module spi_target_port_bench;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sckIn = 1'b0, mosiIn = 1'b0, selN = 1'b1;
  logic       hostWrEn = 1'b0, doneClr = 1'b0;
  logic [7:0] hostWrData = 8'h00;
  logic       misoOut, misoOe, doneFlag, overrunFlag;
  logic [7:0] hostRdData;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_target_port u_spi_target_port (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .mosiIn(mosiIn), .selN(selN),
    .misoOut(misoOut), .misoOe(misoOe), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .doneClr(doneClr),
    .doneFlag(doneFlag), .overrunFlag(overrunFlag)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
    waitCyc(2);
  endtask

  task automatic clearDone();
    @(negedge clk); doneClr = 1'b1;
    @(negedge clk); doneClr = 1'b0;
    waitCyc(2);
  endtask

  task automatic selLow();
    @(negedge clk); selN = 1'b0; waitCyc(HALF);
  endtask

  task automatic selHigh();
    @(negedge clk); selN = 1'b1; waitCyc(HALF);
  endtask

  // Controller model, mode 0: MOSI set while SCK low, MISO sampled before rise.
  task automatic xferBits(input logic [7:0] mo, input int nBits, output logic [7:0] mi);
    mi = 8'h00;
    for (int k = 0; k < nBits; k++) begin
      @(negedge clk); mosiIn = mo[7-k];
      waitCyc(HALF);
      mi[7-k] = misoOut;
      sckIn = 1'b1;
      waitCyc(HALF);
      sckIn = 1'b0;
    end
    waitCyc(HALF);
  endtask

  task automatic testReset();
    check("R1", "misoOe", 32'(misoOe), 32'h0);
    check("R1", "doneFlag", 32'(doneFlag), 32'h0);
    check("R1", "overrunFlag", 32'(overrunFlag), 32'h0);
    check("R1", "hostRdData", 32'(hostRdData), 32'h00);
  endtask

  task automatic testImmediate();
    logic [7:0] mi;
    hostWrite(8'hA5);
    selLow();
    check("R10", "misoOe selected", 32'(misoOe), 32'h1);
    check("R3", "done before byte", 32'(doneFlag), 32'h0);
    xferBits(8'h3C, 8, mi);
    check("R5", "immediate tx byte", 32'(mi), 32'hA5);
    check("R2", "rx byte msb first", 32'(hostRdData), 32'h3C);
    check("R3", "doneFlag", 32'(doneFlag), 32'h1);
    selHigh();
    check("R10", "misoOe idle", 32'(misoOe), 32'h0);
    check("R8", "done held", 32'(doneFlag), 32'h1);
    clearDone();
    check("R8", "done cleared", 32'(doneFlag), 32'h0);
  endtask

  task automatic testEmpty();
    logic [7:0] mi;
    selLow();
    xferBits(8'h96, 8, mi);
    check("R7", "empty sends ones", 32'(mi), 32'hFF);
    check("R3", "rx byte", 32'(hostRdData), 32'h96);
    check("R9", "no overrun", 32'(overrunFlag), 32'h0);
    selHigh();
    clearDone();
  endtask

  task automatic testDoubleBuffer();
    logic [7:0] mi;
    hostWrite(8'h11);
    hostWrite(8'h22);
    selLow();
    xferBits(8'h01, 8, mi);
    check("R5", "first byte", 32'(mi), 32'h11);
    xferBits(8'h02, 8, mi);
    check("R6", "held byte", 32'(mi), 32'h22);
    check("R9", "overrun set", 32'(overrunFlag), 32'h1);
    check("R9", "rx newest", 32'(hostRdData), 32'h02);
    xferBits(8'h03, 8, mi);
    check("R7", "drained sends ones", 32'(mi), 32'hFF);
    check("R4", "rx third", 32'(hostRdData), 32'h03);
    selHigh();
    clearDone();
    check("R9", "overrun cleared", 32'(overrunFlag), 32'h0);
    check("R8", "done cleared", 32'(doneFlag), 32'h0);
  endtask

  task automatic testMidWrite();
    logic [7:0] mi;
    selLow();
    fork
      xferBits(8'h5E, 8, mi);
      begin waitCyc(40); hostWrite(8'h44); end
    join
    check("R6", "byte in flight unaffected", 32'(mi), 32'hFF);
    check("R3", "rx", 32'(hostRdData), 32'h5E);
    xferBits(8'h6F, 8, mi);
    check("R6", "mid-write byte next", 32'(mi), 32'h44);
    selHigh();
    clearDone();
  endtask

  task automatic testAbort();
    logic [7:0] mi;
    hostWrite(8'h5A);
    selLow();
    xferBits(8'hE7, 3, mi);
    check("R2", "partial tx bits", 32'(mi[7:5]), 32'h2);
    selHigh();
    check("R10", "no done on abort", 32'(doneFlag), 32'h0);
    check("R10", "rx unchanged on abort", 32'(hostRdData), 32'h6F);
    selLow();
    xferBits(8'hC3, 8, mi);
    check("R10", "dropped tx byte", 32'(mi), 32'hFF);
    check("R10", "rx after abort", 32'(hostRdData), 32'hC3);
    check("R3", "done after abort", 32'(doneFlag), 32'h1);
    selHigh();
    clearDone();
  endtask

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(4);
    testReset();
    testImmediate();
    testEmpty();
    testDoubleBuffer();
    testMidWrite();
    testAbort();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule